// File: doc/BRIEF.md
# Pseudorandom Self-Test Engine with Signature Compaction

This block runs a logic self-test without help from outside. A small linear feedback shift register drives a pseudorandom pattern onto a bus that feeds a combinational circuit under test. The circuit returns one response bit per clock. A second shift register of the same shape folds that bit into its first stage together with its own feedback. Over the run, the response stream is compacted into a short signature.

A sequencer starts both registers when reset is released. It lets them run for a fixed number of clocks, which by default is one full period of the generator. It then freezes everything and raises `done`. At that point the signature is compared with a golden value, and the result is reported on `pass` and `fail`. An external tester can also read the signature serially by holding `shift_en` high after `done`.

The register width, feedback taps, generator seed, golden signature and run length are all parameters. The defaults describe a 3-bit engine seeded to binary 100. With a two-input AND of the two upper pattern bits as the circuit under test, a fault-free run leaves the signature 011 and a stuck-at-1 output leaves 000.

Top module: `bist_engine`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, the pattern bus shows the seed (default binary 100, value 4). Pattern bit 2 is the first stage, bit 1 the second and bit 0 the third. Each run clock loads bit 2 with bit 1 XOR bit 0, bit 1 with old bit 2, and bit 0 with old bit 1.
- R2: Seeded with all ones, the pattern bus steps through the values 7, 3, 1, 4, 2, 5, 6 and returns to 7 after exactly 7 clocks.
- R3: The pattern bus never shows the all-zeros value while the seed is nonzero.
- R4: Reset clears the signature to 000. Each run clock loads signature bit 2 with bit 1 XOR bit 0 XOR `resp`, bit 1 with old bit 2, and bit 0 with old bit 1.
- R5: `done` is low during reset and for the first CYCLES-1 clocks after reset is released. It goes high on the CYCLES-th clock (default 7). The signature is then the compaction of the responses to the CYCLES patterns, starting with the seed.
- R6: Once `done` is high it stays high until reset. The pattern bus holds its value, and the signature changes only through a shift.
- R7: When `done` rises, `pass` goes high and `fail` low if the signature equals GOLDEN (default 011). Otherwise `fail` goes high and `pass` low. A stuck-at-1 response stream (final signature 000) must give `fail`.
- R8: `pass` and `fail` are both low whenever `done` is low.
- R9: `sout` always shows signature bit 2. Each clock with `shift_en` high after `done` shifts the signature one place toward bit 2 and fills with 0, so the bits leave most significant first. `pass` and `fail` do not change while shifting.
- R10: `shift_en` has no effect before `done`. A run with it held high ends with the same verdict and signature as a run without it.
- R11: Asserting reset after a completed run restarts the whole test from the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a run |
| pattern | output | N | Test pattern to the circuit under test |
| resp | input | 1 | Response bit from the circuit under test |
| shift_en | input | 1 | Serial shift of the signature after done |
| done | output | 1 | Run complete, signature frozen |
| pass | output | 1 | Signature matched GOLDEN |
| fail | output | 1 | Signature mismatched GOLDEN |
| sout | output | 1 | Serial signature output, most significant bit first |

## Verification
The bench follows the pattern bus on every clock against its own model. An off-by-one run length, or a swapped tap, would show the wrong value at some step or raise `done` one clock early or late. It runs a fault-free circuit and a stuck-at-1 circuit. A compactor that dropped the response bit, or compared before the last clock, would give the same verdict for both. It shifts the signature out, which would expose a reversed bit order, a verdict that follows the shifting register, or a shift that is accepted during the run. A second instance with an all-ones seed and a doubled run length confirms the 7-value sequence and its period.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HOLD = 1'b1
  } bist_phase_e;
endpackage

// File: rtl/bist_lfsr.sv
// Shift register with XOR feedback into the top stage; optional serial
// fold-in, serial shift-out and lockup guard.
module bist_lfsr #(
  parameter int          N        = 3,
  parameter logic [N-1:0] TAPS    = 3'b011,
  parameter logic [N-1:0] SEED    = 3'b100,
  parameter bit          GUARD_NZ = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         shift,
  input  logic         sin,
  output logic [N-1:0] q,
  output logic [N-1:0] q_nxt
);
  logic fb;

  always_comb begin
    fb    = (^(q & TAPS)) ^ sin;
    q_nxt = {fb, q[N-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= SEED;
    else if (adv)   q <= q_nxt;
    else if (shift) q <= {q[N-2:0], 1'b0};
  end

  // R6: nothing moves when neither advancing nor shifting
  a_r6_hold_still: assert property (@(posedge clk) disable iff (rst)
    (!adv && !shift) |=> $stable(q));

  generate
    if (GUARD_NZ) begin : g_guard
      // R3: generator never locks into all zeros
      a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        q != '0);
    end
  endgenerate
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int CYCLES = 7
) (
  input  logic clk,
  input  logic rst,
  output logic adv,
  output logic last,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  bist_phase_e   phase;
  logic [CW-1:0] cnt;

  always_comb begin
    adv  = (phase == PH_RUN);
    last = adv && (cnt == CW'(CYCLES - 1));
    done = (phase == PH_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_RUN;
      cnt   <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (last) phase <= PH_HOLD;
    end
  end

  // R5: done only after exactly CYCLES run clocks
  a_r5_done_at_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == CW'(CYCLES)));
  a_r5_run_below_count: assert property (@(posedge clk) disable iff (rst)
    !done |-> (cnt < CW'(CYCLES)));
  // R6: done is sticky until reset
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
endmodule

// File: rtl/bist_cmp.sv
module bist_cmp #(
  parameter int           N      = 3,
  parameter logic [N-1:0] GOLDEN = 3'b011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         last,
  input  logic         done,
  input  logic [N-1:0] sig_nxt,
  output logic         pass,
  output logic         fail
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (last) begin
      pass <= (sig_nxt == GOLDEN);
      fail <= (sig_nxt != GOLDEN);
    end
  end

  // R8: no verdict before the run ends
  a_r8_quiet_early: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!pass && !fail));
  // R7: exactly one verdict once done
  a_r7_one_verdict: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fail));
  // R9: verdict does not follow the shifting register
  a_r9_verdict_held: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(pass) && $stable(fail)));
endmodule

// File: rtl/bist_engine.sv
module bist_engine #(
  parameter int           N      = 3,
  parameter logic [N-1:0] TAPS   = 3'b011,
  parameter logic [N-1:0] SEED   = 3'b100,
  parameter logic [N-1:0] GOLDEN = 3'b011,
  parameter int           CYCLES = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [N-1:0] pattern,
  input  logic         resp,
  input  logic         shift_en,
  output logic         done,
  output logic         pass,
  output logic         fail,
  output logic         sout
);
  logic         adv;
  logic         last;
  logic [N-1:0] gen_nxt;
  logic [N-1:0] sig;
  logic [N-1:0] sig_nxt;

  bist_seq #(.CYCLES(CYCLES)) u_seq (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .last(last),
    .done(done)
  );

  bist_lfsr #(.N(N), .TAPS(TAPS), .SEED(SEED), .GUARD_NZ(1'b1)) u_gen (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .shift(1'b0),
    .sin  (1'b0),
    .q    (pattern),
    .q_nxt(gen_nxt)
  );

  bist_lfsr #(.N(N), .TAPS(TAPS), .SEED('0), .GUARD_NZ(1'b0)) u_sig (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .shift(done & shift_en),
    .sin  (resp),
    .q    (sig),
    .q_nxt(sig_nxt)
  );

  bist_cmp #(.N(N), .GOLDEN(GOLDEN)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .last   (last),
    .done   (done),
    .sig_nxt(sig_nxt),
    .pass   (pass),
    .fail   (fail)
  );

  assign sout = sig[N-1];

  // R1: generator follows its next-state rule on each run clock
  a_r1_gen_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !$past(rst)) |-> (pattern == {$past(pattern[1]) ^ $past(pattern[0]),
                                          $past(pattern[2]), $past(pattern[1])})
                          || $past(!adv));
  // R10: shift request ignored while running
  a_r10_no_early_shift: assert property (@(posedge clk) disable iff (rst)
    (!done && shift_en) |=> !done || (pass || fail));
endmodule

// File: tb/bist_engine_tb.sv
`timescale 1ns/1ps
module bist_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pattern, pattern2;
  logic       resp, shift_en;
  logic       done, pass, fail, sout;
  logic       done2, pass2, fail2, sout2;
  int         stuck = 0;     // 0 none, 1 stuck-at-1, 2 stuck-at-0
  int         n_vec = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;      // 250 MHz

  // Circuit under test: AND of pattern bits 2 and 1
  always_comb begin
    case (stuck)
      1:       resp = 1'b1;
      2:       resp = 1'b0;
      default: resp = pattern[2] & pattern[1];
    endcase
  end

  bist_engine u_dut (
    .clk(clk), .rst(rst), .pattern(pattern), .resp(resp),
    .shift_en(shift_en), .done(done), .pass(pass), .fail(fail), .sout(sout)
  );

  bist_engine #(.SEED(3'b111), .CYCLES(14)) u_dut_ones (
    .clk(clk), .rst(rst), .pattern(pattern2), .resp(1'b0),
    .shift_en(1'b0), .done(done2), .pass(pass2), .fail(fail2), .sout(sout2)
  );

  function automatic logic [2:0] gen_step(logic [2:0] v);
    return {v[1] ^ v[0], v[2], v[1]};
  endfunction

  function automatic logic [2:0] sig_step(logic [2:0] s, logic b);
    return {s[1] ^ s[0] ^ b, s[2], s[1]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // Runs one test; returns the model signature
  task automatic run_and_check(int mode, logic sh, output logic [2:0] msig);
    logic [2:0] mgen;
    stuck    = mode;
    shift_en = sh;
    do_reset();
    mgen = 3'b100;
    msig = 3'b000;
    check("R1 seed on pattern", pattern, 4);
    check("R8 pass low at start", pass, 0);
    check("R8 fail low at start", fail, 0);
    for (int k = 1; k <= 7; k++) begin
      msig = sig_step(msig, resp);
      mgen = gen_step(mgen);
      @(negedge clk);
      check("R1 pattern step", pattern, mgen);
      check("R3 nonzero pattern", (pattern != 0), 1);
      check("R5 done timing", done, (k == 7));
      if (k < 7) check("R8 no verdict early", pass | fail, 0);
    end
    check("R7 pass verdict", pass, (msig == 3'b011));
    check("R7 fail verdict", fail, (msig != 3'b011));
    shift_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 pattern frozen", pattern, mgen);
      check("R6 done sticky", done, 1);
      check("R6 signature frozen", sout, msig[2]);
    end
  endtask

  task automatic t_good();
    logic [2:0] s;
    run_and_check(0, 1'b0, s);
    check("R4 model signature good", s, 3);
    check("R7 good passes", pass, 1);
  endtask

  task automatic t_shift();
    logic [2:0] s;
    run_and_check(0, 1'b0, s);
    check("R9 first bit", sout, s[2]);
    shift_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R9 shifted bit", sout, (k < 3) ? s[2-k] : 0);
      check("R9 pass held", pass, 1);
      check("R9 fail held", fail, 0);
    end
    shift_en = 1'b0;
  endtask

  task automatic t_stuck();
    logic [2:0] s;
    run_and_check(1, 1'b0, s);
    check("R7 stuck-at-1 signature", s, 0);
    check("R7 stuck-at-1 fails", fail, 1);
    check("R7 stuck-at-1 no pass", pass, 0);
    run_and_check(2, 1'b0, s);
    check("R7 stuck-at-0 fails", fail, 1);
  endtask

  task automatic t_early_shift();
    logic [2:0] s;
    run_and_check(0, 1'b1, s);
    check("R10 verdict unaffected", pass, 1);
    check("R10 signature msb unaffected", sout, s[2]);
  endtask

  task automatic t_restart();
    logic [2:0] s;
    run_and_check(1, 1'b0, s);
    run_and_check(0, 1'b0, s);
    check("R11 restart passes", pass, 1);
  endtask

  task automatic t_ones();
    logic [2:0] m;
    do_reset();
    m = 3'b111;
    check("R2 ones seed", pattern2, 7);
    for (int k = 1; k <= 14; k++) begin
      m = gen_step(m);
      @(negedge clk);
      check("R2 sequence step", pattern2, m);
      if (k == 7 || k == 14) check("R2 period 7", pattern2, 7);
      check("R5 done at 14", done2, (k == 14));
    end
  endtask

  initial begin
    shift_en = 1'b0;
    t_good();
    t_shift();
    t_stuck();
    t_early_shift();
    t_restart();
    t_ones();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule